// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block receives divider settings for a frequency synthesizer over a three-wire, write-only serial port. The three wires are a shift clock, a data line and a load strobe. The wires are asynchronous to the block clock. They pass through a synchronizer, and the block then finds edges on the shift clock and on the load strobe. On each shift-clock rising edge seen while the load strobe is low, one data bit enters a 19-bit shift register, most significant bit first.

A rising load strobe copies the shift register into one of two holding registers. The last bit shifted in selects which one. The feedback register holds a 7-bit swallow count and an 11-bit main count. The reference register holds a 14-bit reference ratio and four mode flags: pump current, multifunction output select, detector polarity and prescaler modulus. The held values drive the divider and detector logic directly.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset the outputs read main count 3, reference ratio 3, swallow count 0, and all four mode flags 0.
- R2: A data bit is taken on each rising edge of the shift clock while the load strobe is low, first bit most significant. With the 19-bit frame written as F[18:0] (F[18] sent first, F[0] sent last), F[0]=0 marks a feedback frame. Such a frame loads swallow count = F[7:1] and main count = F[18:8].
- R3: When F[0]=1 the frame is a reference frame. It loads reference ratio = F[14:1], prescaler flag (1 = 32/33, 0 = 64/65) = F[15], detector polarity flag = F[16], output select flag (1 = divided frequency, 0 = lock detect; 0 in normal use) = F[17], and pump current flag (1 = high current) = F[18], the first bit sent.
- R4: A load updates only the register named by F[0]; the other register keeps its value.
- R5: Shift-clock edges that arrive while the load strobe is high neither shift the register nor trigger a new load. Only a rising edge of the load strobe loads.
- R6: Only the last 19 bits shifted before a load count. Earlier extra bits are discarded.
- R7: The outputs do not change while bits are being shifted. They change only after a load-strobe rising edge, within SYNC_STAGES+2 block-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk | input | 1 | Serial shift clock, asynchronous |
| cfg_data | input | 1 | Serial data, asynchronous |
| cfg_load | input | 1 | Load strobe, asynchronous |
| swallow_cnt | output | 7 | Held swallow count |
| main_cnt | output | 11 | Held main count |
| ref_ratio | output | 14 | Held reference ratio |
| pump_high | output | 1 | High pump current selected |
| out_sel_freq | output | 1 | Multifunction output shows divided frequency |
| pd_pos_pol | output | 1 | Detector polarity for a positive tuning slope |
| mod_small | output | 1 | Prescaler modulus 32/33 selected (else 64/65) |

## Verification
The hardest case to reach is shift-clock activity while the load strobe is held high. A design that wrongly shifts or reloads here can look correct, because reloading an unchanged register changes nothing visible. The stimulus therefore loads a feedback frame and keeps the strobe high. It then pulses the shift clock with ones and pulses the strobe again without sending a new frame. Any stray shift turns the control bit into a one and moves the garbage into the reference register, where the check sees it. Random frames of both kinds, extra leading bits, and checks of the outputs in the middle of a frame cover the rest.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int FRAME_W   = 19;
    localparam int SWALLOW_W = 7;
    localparam int MAIN_W    = 11;
    localparam int RATIO_W   = 14;
    localparam int FLAG_W    = 4;
    localparam int PAYLOAD_W = FRAME_W - 1;

    typedef enum logic {
        DEST_FB  = 1'b0,
        DEST_REF = 1'b1
    } dest_e;

    typedef struct packed {
        logic [MAIN_W-1:0]    main_cnt;
        logic [SWALLOW_W-1:0] swallow;
    } fb_word_t;

    typedef struct packed {
        logic               pump_high;
        logic               out_sel_freq;
        logic               pd_pos_pol;
        logic               mod_small;
        logic [RATIO_W-1:0] ratio;
    } ref_word_t;

    localparam fb_word_t FB_RESET = '{
        main_cnt: MAIN_W'(3),
        swallow:  '0
    };

    localparam ref_word_t REF_RESET = '{
        pump_high:    1'b0,
        out_sel_freq: 1'b0,
        pd_pos_pol:   1'b0,
        mod_small:    1'b0,
        ratio:        RATIO_W'(3)
    };

    function automatic dest_e frame_dest(input logic [FRAME_W-1:0] f);
        return dest_e'(f[0]);
    endfunction

    function automatic fb_word_t frame_to_fb(input logic [FRAME_W-1:0] f);
        return fb_word_t'(f[FRAME_W-1:1]);
    endfunction

    function automatic ref_word_t frame_to_ref(input logic [FRAME_W-1:0] f);
        return ref_word_t'(f[FRAME_W-1:1]);
    endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter
    import scl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame
);
    always_ff @(posedge clk) begin
        if (rst)           frame <= '0;
        else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
    end

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> frame[0] == $past(bit_in));
endmodule

// File: rtl/scl_latches.sv
module scl_latches
    import scl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output fb_word_t           fb_q,
    output ref_word_t          ref_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q  <= FB_RESET;
            ref_q <= REF_RESET;
        end else if (load) begin
            case (frame_dest(frame))
                DEST_FB:  fb_q  <= frame_to_fb(frame);
                DEST_REF: ref_q <= frame_to_ref(frame);
                default:  ;
            endcase
        end
    end

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fb_q == FB_RESET && ref_q == REF_RESET));

    assert_fb_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (load && frame[0]) |=> $stable(fb_q));

    assert_ref_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (load && !frame[0]) |=> $stable(ref_q));

    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(fb_q) && $stable(ref_q)));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_clk,
    input  logic                 cfg_data,
    input  logic                 cfg_load,
    output logic [SWALLOW_W-1:0] swallow_cnt,
    output logic [MAIN_W-1:0]    main_cnt,
    output logic [RATIO_W-1:0]   ref_ratio,
    output logic                 pump_high,
    output logic                 out_sel_freq,
    output logic                 pd_pos_pol,
    output logic                 mod_small
);
    localparam int NSIG = 3;

    logic [NSIG-1:0]    pins_s;
    logic               sclk_s, sdat_s, sld_s;
    logic               sclk_d, sld_d;
    logic               sclk_rise, sld_rise, shift_en;
    logic [FRAME_W-1:0] frame;
    fb_word_t           fb_q;
    ref_word_t          ref_q;

    scl_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({cfg_load, cfg_data, cfg_clk}),
        .d_out (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign sdat_s = pins_s[1];
    assign sld_s  = pins_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sld_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sld_d  <= sld_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sld_rise  = sld_s & ~sld_d;
    assign shift_en  = sclk_rise & ~sld_s;

    scl_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (sdat_s),
        .frame    (frame)
    );

    scl_latches u_latch (
        .clk   (clk),
        .rst   (rst),
        .load  (sld_rise),
        .frame (frame),
        .fb_q  (fb_q),
        .ref_q (ref_q)
    );

    assign swallow_cnt  = fb_q.swallow;
    assign main_cnt     = fb_q.main_cnt;
    assign ref_ratio    = ref_q.ratio;
    assign pump_high    = ref_q.pump_high;
    assign out_sel_freq = ref_q.out_sel_freq;
    assign pd_pos_pol   = ref_q.pd_pos_pol;
    assign mod_small    = ref_q.mod_small;

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        sld_s |=> $stable(frame));

    assert_single_load_R5: assert property (@(posedge clk) disable iff (rst)
        sld_rise |=> !sld_rise);
endmodule

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_clk = 1'b0, cfg_data = 1'b0, cfg_load = 1'b0;
    logic [6:0]  swallow_cnt;
    logic [10:0] main_cnt;
    logic [13:0] ref_ratio;
    logic pump_high, out_sel_freq, pd_pos_pol, mod_small;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0]  e_sw   = 7'd0;
    logic [10:0] e_main = 11'd3;
    logic [13:0] e_rat  = 14'd3;
    logic [3:0]  e_flg  = 4'd0;

    always #5 clk = ~clk;

    serial_cfg_loader dut (
        .clk(clk), .rst(rst), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
        .cfg_load(cfg_load), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
        .ref_ratio(ref_ratio), .pump_high(pump_high), .out_sel_freq(out_sel_freq),
        .pd_pos_pol(pd_pos_pol), .mod_small(mod_small)
    );

    function automatic logic [18:0] fb_frame(input logic [6:0] s, input logic [10:0] m);
        return {m, s, 1'b0};
    endfunction

    function automatic logic [18:0] ref_frame(input logic [3:0] flg, input logic [13:0] r);
        return {flg, r, 1'b1};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " swallow"}, 32'(swallow_cnt), 32'(e_sw));
        chk({tag, " main"},    32'(main_cnt),    32'(e_main));
        chk({tag, " ratio"},   32'(ref_ratio),   32'(e_rat));
        chk({tag, " flags"},   32'({pump_high, out_sel_freq, pd_pos_pol, mod_small}), 32'(e_flg));
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            cfg_data = v[i];
            wait_clk(2);
            cfg_clk = 1'b1;
            wait_clk(3);
            cfg_clk = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic pulse_load();
        cfg_load = 1'b1;
        wait_clk(6);
        cfg_load = 1'b0;
        wait_clk(4);
    endtask

    task automatic expect_frame(input logic [18:0] f);
        if (f[0]) begin
            e_rat = f[14:1];
            e_flg = f[18:15];
        end else begin
            e_sw   = f[7:1];
            e_main = f[18:8];
        end
    endtask

    task automatic load_frame(input logic [18:0] f);
        send_bits(32'(f), 19);
        pulse_load();
        expect_frame(f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [18:0] f;
        void'($urandom(32'd5150));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        chk_all("R1 reset");

        load_frame(fb_frame(7'd0, 11'd3));
        chk_all("R2 fb min");
        load_frame(fb_frame(7'd127, 11'd2047));
        chk_all("R2 fb max, R4 ref kept");

        load_frame(ref_frame(4'b1111, 14'd16383));
        chk_all("R3 ref max, R4 fb kept");
        load_frame(ref_frame(4'b1000, 14'd3));
        chk_all("R3 pump flag first bit");
        load_frame(ref_frame(4'b0001, 14'h2AAA));
        chk_all("R3 modulus flag");

        // R7: half a frame shifted, outputs untouched
        f = fb_frame(7'h55, 11'h2A5);
        send_bits(32'(f >> 9), 10);
        chk_all("R7 mid frame");
        send_bits(32'(f), 9);
        chk_all("R7 before load");
        pulse_load();
        expect_frame(f);
        chk_all("R7 after load");

        // R6: leading junk bits discarded
        send_bits(32'h3F, 6);
        load_frame(ref_frame(4'b0110, 14'h1234));
        chk_all("R6 extra leading bits");

        // R5: shift clock while load strobe high
        load_frame(fb_frame(7'h12, 11'h345));
        cfg_load = 1'b1;
        wait_clk(6);
        cfg_data = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cfg_clk = 1'b1; wait_clk(3);
            cfg_clk = 1'b0; wait_clk(3);
        end
        chk_all("R5 no reload while high");
        cfg_load = 1'b0;
        wait_clk(4);
        pulse_load();
        chk_all("R5 no shift while high");

        for (int n = 0; n < 24; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0])
                f = ref_frame(r[4:1], 14'(3 + (r[31:18] % 14'd16381)));
            else
                f = fb_frame(r[7:1], 11'(3 + (r[31:21] % 11'd2045)));
            load_frame(f);
            chk_all(f[0] ? "R3 R4 random ref" : "R2 R4 random fb");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule